// File: doc/BRIEF.md
# Seven-to-one pixel lane serializer

This block turns one dual-pixel word per pixel clock into serial sub-symbols on eight data lanes, and adds a framing clock lane that the receiving end uses to find word boundaries. A word holds two 24-bit colour values (pixel A and pixel B) and three control bits: horizontal sync, vertical sync and data enable. Every lane sends seven sub-symbols per pixel period. The bit clock runs at seven times the pixel rate and is an input to the block. A load strobe, one bit clock wide and aligned to the pixel phase, marks the start of each new word.

Input words are captured on a pixel clock edge that the user selects. They are then moved into a hold register in the bit clock domain, so the next word can be captured while the current one is still being shifted out. The framing clock comes out on two identical outputs. In single-pixel mode the upper four lanes and the second clock output are turned off. An active-low power-down turns off every output. After reset, or after power-down is released, the outputs stay low until a new word has been loaded.

Top module: `pix_lane_ser`

## Requirements
- R1: A slot counter in the bit clock domain returns to slot 0 on the bit clock edge that samples `load_i` high. It then counts up by one each bit clock and wraps from 6 to 0. Slot s of the word appears on the lanes during the s-th bit clock after the load edge.
- R2: Lanes are grouped in two halves: lanes 0-3 carry pixel A and lanes 4-7 carry pixel B. For lane L at slot s, the index is k = (L mod 4)*7 + s. In the lower half, k < 24 sends pix_a[k], k = 24 sends pix_a[23] again, k = 25 sends hsync, k = 26 sends vsync and k = 27 sends DE. In the upper half, k < 24 sends pix_b[k], k = 24 sends pix_b[23] again, k = 25 sends DE, and k = 26 and 27 send 0.
- R3: `fclk_a_o` is high during slots 5, 6, 0 and 1 and low during slots 2, 3 and 4. Its rising edge therefore comes two slots ahead of slot 0.
- R4: In dual mode, `fclk_b_o` always equals `fclk_a_o`.
- R5: With `rise_cap_i` = 1 the loaded word is the one present at the last rising `pclk_i` edge before the load. With `rise_cap_i` = 0 it is the one present at the last falling edge.
- R6: The word being sent does not change between two loads, even when the inputs change while it is being sent.
- R7: With `single_i` = 1, lanes 4-7 and `fclk_b_o` are 0, and lanes 0-3 and `fclk_a_o` behave as in dual mode.
- R8: While `pd_ni` = 0, all lane and clock outputs and all enables are 0.
- R9: After reset, or after `pd_ni` returns high, all lanes and both clocks stay 0 until a load edge is sampled with `pd_ni` = 1.
- R10: With `pd_ni` = 1, `lane_en_o` is 0xFF in dual mode and 0x0F in single mode, and `clk_en_o` is {~single, 1}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Bit clock, seven times the pixel rate |
| pclk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | One bit clock wide, marks slot 0 of the next word |
| pd_ni | input | 1 | Power-down, active low, synchronous to bclk_i |
| rise_cap_i | input | 1 | 1: capture on rising pclk edge, 0: on falling edge |
| single_i | input | 1 | 1: single-pixel mode, upper lanes off |
| pix_a_i | input | 24 | Pixel A colour |
| pix_b_i | input | 24 | Pixel B colour |
| hsync_i | input | 1 | Horizontal sync |
| vsync_i | input | 1 | Vertical sync |
| de_i | input | 1 | Data enable |
| lane_o | output | 8 | Serial data lanes |
| lane_en_o | output | 8 | Per-lane driver enable |
| fclk_a_o | output | 1 | Framing clock |
| fclk_b_o | output | 1 | Copy of the framing clock |
| clk_en_o | output | 2 | Enables for fclk_b_o (bit 1) and fclk_a_o (bit 0) |

## Verification
The clock-shape assertion assumes that `load_i` arrives exactly once every seven bit clocks, so that each frame lasts its full seven slots. The bench always drives the strobe on that fixed phase. The assertions and the capture model also assume that the pixel clock edges and the data changes never fall in the same instant as a bit clock rising edge, and that data is stable across the capturing edge. The bench therefore moves the pixel clock, the data, the mode pins and power-down only at bit clock falling edges, on phases that never overlap. When it tests edge selection, it changes the data between the rising and the falling pixel edge.

// File: rtl/pls_pkg.sv
package pls_pkg;
  localparam int COLOR_W  = 24;
  localparam int LANES    = 8;
  localparam int SLOTS    = 7;
  localparam int CLK_HIGH = 4;
  localparam int CLK_LEAD = 2;
  localparam int HALF     = LANES / 2;
  localparam int SLOT_W   = $clog2(SLOTS);

  typedef struct packed {
    logic               de;
    logic               vs;
    logic               hs;
    logic [COLOR_W-1:0] pix_b;
    logic [COLOR_W-1:0] pix_a;
  } word_t;
endpackage

// File: rtl/pls_capture.sv
module pls_capture
  import pls_pkg::*;
(
  input  logic  pclk_i,
  input  logic  rst_ni,
  input  logic  rise_sel_i,
  input  word_t word_i,
  output word_t word_o
);
  word_t pos_q, neg_q;

  always_ff @(posedge pclk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else         pos_q <= word_i;
  end

  always_ff @(negedge pclk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= '0;
    else         neg_q <= word_i;
  end

  assign word_o = rise_sel_i ? pos_q : neg_q;
endmodule

// File: rtl/pls_slot_ctr.sv
module pls_slot_ctr
  import pls_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  output logic [SLOT_W-1:0] slot_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);
  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        slot_q <= '0;
    else if (load_i || slot_q == LAST)  slot_q <= '0;
    else                                slot_q <= slot_q + 1'b1;
  end

  assign slot_o = slot_q;

  a_r1_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> slot_q == '0);
  a_r1_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && slot_q == LAST) |=> slot_q == '0);
  a_r1_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && slot_q < LAST) |=> slot_q == $past(slot_q) + 1'b1);
endmodule

// File: rtl/pls_lane_map.sv
module pls_lane_map
  import pls_pkg::*;
(
  input  word_t             word_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [LANES-1:0]  bit_o,
  output logic              fclk_o
);
  function automatic logic pick(word_t w, int half, int k);
    logic [COLOR_W-1:0] c;
    c = (half == 0) ? w.pix_a : w.pix_b;
    if (k < COLOR_W)  return c[k];
    if (k == COLOR_W) return c[COLOR_W-1];
    if (half == 0) begin
      if (k == COLOR_W + 1) return w.hs;
      if (k == COLOR_W + 2) return w.vs;
      return w.de;
    end
    if (k == COLOR_W + 1) return w.de;
    return 1'b0;
  endfunction

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int H   = l / HALF;
    localparam int LOC = l % HALF;
    assign bit_o[l] = pick(word_i, H, LOC * SLOTS + int'(slot_i));
  end

  assign fclk_o = ((int'(slot_i) + CLK_LEAD) % SLOTS) < CLK_HIGH;
endmodule

// File: rtl/pix_lane_ser.sv
module pix_lane_ser
  import pls_pkg::*;
(
  input  logic               bclk_i,
  input  logic               pclk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               pd_ni,
  input  logic               rise_cap_i,
  input  logic               single_i,
  input  logic [COLOR_W-1:0] pix_a_i,
  input  logic [COLOR_W-1:0] pix_b_i,
  input  logic               hsync_i,
  input  logic               vsync_i,
  input  logic               de_i,
  output logic [LANES-1:0]   lane_o,
  output logic [LANES-1:0]   lane_en_o,
  output logic               fclk_a_o,
  output logic               fclk_b_o,
  output logic [1:0]         clk_en_o
);
  word_t             in_word, cap_word, hold_q;
  logic [SLOT_W-1:0] slot;
  logic [LANES-1:0]  lane_bits;
  logic              fclk, live_q;

  assign in_word = '{de: de_i, vs: vsync_i, hs: hsync_i, pix_b: pix_b_i, pix_a: pix_a_i};

  pls_capture u_cap (
    .pclk_i     (pclk_i),
    .rst_ni     (rst_ni),
    .rise_sel_i (rise_cap_i),
    .word_i     (in_word),
    .word_o     (cap_word)
  );

  pls_slot_ctr u_slot (
    .clk_i  (bclk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .slot_o (slot)
  );

  // second stage of the double buffer, bit clock domain
  always_ff @(posedge bclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      live_q <= 1'b0;
    end else begin
      if (load_i) hold_q <= cap_word;
      live_q <= pd_ni & (live_q | load_i);
    end
  end

  pls_lane_map u_map (
    .word_i (hold_q),
    .slot_i (slot),
    .bit_o  (lane_bits),
    .fclk_o (fclk)
  );

  assign lane_en_o = !pd_ni   ? '0 :
                     single_i ? {{(LANES-HALF){1'b0}}, {HALF{1'b1}}} : '1;
  assign clk_en_o  = pd_ni ? {~single_i, 1'b1} : 2'b00;
  assign lane_o    = lane_bits & lane_en_o & {LANES{live_q}};
  assign fclk_a_o  = fclk & live_q & clk_en_o[0];
  assign fclk_b_o  = fclk & live_q & clk_en_o[1];

  a_r8_pd_quiet: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    !pd_ni |-> (lane_o == '0 && !fclk_a_o && !fclk_b_o && lane_en_o == '0));
  a_r7_single_off: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    (pd_ni && single_i) |-> (lane_o[LANES-1:HALF] == '0 && !fclk_b_o));
  a_r9_wait_load: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    ($past(!pd_ni) && !$past(load_i)) |-> (lane_o == '0 && !fclk_a_o));
  a_r3_clk_lead: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    (live_q && pd_ni && $past(live_q) && $past(pd_ni) && $rose(fclk_a_o))
      |-> slot == SLOT_W'(SLOTS - CLK_LEAD));
endmodule

// File: tb/sim_pix_lane_ser.sv
module sim_pix_lane_ser;
  logic bclk = 1'b0, pclk = 1'b0, rst_n = 1'b0, load = 1'b0, pd_n = 1'b1;
  logic rise = 1'b1, single = 1'b0;
  logic [50:0] cur = '0;
  logic [7:0] lane, lane_en;
  logic fclk_a, fclk_b;
  logic [1:0] clk_en;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 bclk = ~bclk;

  pix_lane_ser u0 (
    .bclk_i(bclk), .pclk_i(pclk), .rst_ni(rst_n), .load_i(load), .pd_ni(pd_n),
    .rise_cap_i(rise), .single_i(single),
    .pix_a_i(cur[23:0]), .pix_b_i(cur[47:24]), .hsync_i(cur[48]),
    .vsync_i(cur[49]), .de_i(cur[50]),
    .lane_o(lane), .lane_en_o(lane_en), .fclk_a_o(fclk_a), .fclk_b_o(fclk_b),
    .clk_en_o(clk_en));

  // word layout: a=[23:0] b=[47:24] hs=48 vs=49 de=50
  function automatic logic exp_bit(logic [50:0] w, int ln, int s);
    int k;
    k = (ln % 4) * 7 + s;
    if (ln < 4) begin
      if (k < 24) return w[k];
      if (k == 24) return w[23];
      if (k == 25) return w[48];
      if (k == 26) return w[49];
      return w[50];
    end
    if (k < 24) return w[24 + k];
    if (k == 24) return w[47];
    if (k == 25) return w[50];
    return 1'b0;
  endfunction

  function automatic logic exp_clk(int s);
    return (s == 5) || (s == 6) || (s == 0) || (s == 1);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int c, fr, chg, s;
    logic [50:0] frame, pend_word, exp_rise, exp_fall;
    logic live_exp, pend_live;
    logic [7:0] el, een;
    string tag;
    c = 6; fr = 0; chg = 2;
    frame = '0; pend_word = '0; exp_rise = '0; exp_fall = '0;
    live_exp = 0; pend_live = 0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge bclk);
    rst_n = 1'b1;
    while (fr < 300) begin
      @(negedge bclk);
      c = (c + 1) % 7;
      if (c == 1) begin
        frame = pend_word;
        live_exp = live_exp | pend_live;
        pend_live = 0;
      end
      // sample
      s = (c + 6) % 7;
      el = '0;
      if (pd_n && live_exp)
        for (int l = 0; l < 8; l++)
          el[l] = (single && l >= 4) ? 1'b0 : exp_bit(frame, l, s);
      if (!pd_n) tag = "R8";
      else if (!live_exp) tag = "R9";
      else if (chg == 4) tag = "R5";
      else if (s == 6) tag = "R1";
      else if (s >= 2) tag = "R6";
      else tag = "R2";
      chk(tag, {4'h0, lane[3:0]}, {4'h0, el[3:0]});
      chk((pd_n && single) ? "R7" : tag, {4'h0, lane[7:4]}, {4'h0, el[7:4]});
      chk(!pd_n ? "R8" : !live_exp ? "R9" : "R3", {7'h0, fclk_a},
          {7'h0, pd_n && live_exp && exp_clk(s)});
      chk(!pd_n ? "R8" : single ? "R7" : "R4", {7'h0, fclk_b},
          {7'h0, pd_n && live_exp && !single && exp_clk(s)});
      een = !pd_n ? 8'h00 : single ? 8'h0F : 8'hFF;
      chk(pd_n ? "R10" : "R8", lane_en, een);
      chk(pd_n ? "R10" : "R8", {6'h0, clk_en}, {6'h0, pd_n ? {~single, 1'b1} : 2'b00});
      // drive
      if (c == 1) begin
        fr++;
        chg = (fr % 5 == 3) ? 4 : 2;
        if (fr < 40) rise = 1'b1;
        else if (fr < 80) rise = 1'b0;
        else if (fr % 16 == 0) rise = 1'($urandom);
        single = ((fr >= 60 && fr < 90) || (fr >= 200 && fr < 230));
        pd_n = !((fr >= 120 && fr < 123) || (fr >= 260 && fr < 262));
        if (!pd_n) begin live_exp = 0; pend_live = 0; end
      end
      load = (c == 0);
      if (c == 0) begin
        pend_word = rise ? exp_rise : exp_fall;
        pend_live = pd_n;
      end
      if (c == chg) begin
        if (fr == 10) cur = '1;
        else if (fr == 11) cur = '0;
        else if (fr == 12) cur = {3'b010, {24{2'b10}}};
        else cur = {19'($urandom), $urandom};
      end
      if (c == 3) begin pclk = 1'b1; exp_rise = cur; end
      if (c == 5) begin pclk = 1'b0; exp_fall = cur; end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule